// File: doc/BRIEF.md
# Variable-Length Bit Extraction Buffer

This block turns a stream of fixed 32-bit words into pieces of 0 to 15 bits. The producer writes whole words with a single strobe. The consumer raises a request strobe with a 4-bit length. The block then removes exactly that many bits from the oldest unread end of the stream. The bits come out right-aligned on a 15-bit port, with a one-cycle valid pulse.

Inside, the words sit in a circular store of 32 slots. A 10-bit read pointer addresses single bits: the upper 5 bits pick the slot and the lower 5 bits give the offset within it. The block never shifts the whole 1024-bit store. For each request it fetches only the current word and the word after it, and a staged barrel shifter aligns the pair by the offset. A piece can therefore cross a word boundary without a gap. Unread bits are counted, and the block rejects pushes into a full store and requests that ask for more bits than it holds.

Top module: `bitx_buffer`

## Requirements
- R1: While `rst` is high, at a rising edge, `bit_level`, `full`, `out_valid`, `out_data`, `overflow` and `underflow` are all cleared to zero.
- R2: A push into a store that is not full writes `push_data` into the next slot, and `bit_level` rises by 32 after that edge.
- R3: A push while `full` is high is dropped. `overflow` is high for the one cycle after that edge, and the pushed word never shows up in any later output.
- R4: An accepted request of length L puts out the L oldest unread bits, oldest in bit 0, on `out_data`. Bits L and above are zero. `out_valid` is high in the cycle after the request, and the piece is removed from the stream.
- R5: When a piece runs past bit 31 of the current word, the remaining high bits of that word are followed directly by bit 0 upward of the next word.
- R6: A request of length 0 is accepted. It gives `out_valid` with `out_data` equal to zero and leaves `bit_level` and the read position unchanged.
- R7: A request whose length is larger than `bit_level` is rejected. `underflow` is high for the one cycle after it, `out_valid` stays low, and no unread bit is consumed.
- R8: A push and a request in the same cycle are both carried out. The request is judged against the bits held before that edge.
- R9: `full` is high exactly when all 32 slots hold unread bits. A slot is freed in the same edge at which the read offset passes the end of its word.
- R10: The write and read positions wrap around the 32-slot store with no break in the bit stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write strobe for one word |
| push_data | input | 32 | Word to store |
| req | input | 1 | Extraction request strobe |
| req_len | input | 4 | Number of bits to extract, 0 to 15 |
| out_valid | output | 1 | Pulse: extracted bits are on `out_data` |
| out_data | output | 15 | Extracted bits, right-aligned, upper bits zero |
| full | output | 1 | All word slots are occupied |
| bit_level | output | 11 | Count of stored unread bits, 0 to 1024 |
| overflow | output | 1 | Pulse: a push was dropped |
| underflow | output | 1 | Pulse: a request was rejected |

## Verification
The hardest state to reach is a full store in the same cycle as a request that frees a slot and a push that must still be dropped, because the push is judged on the occupancy before that edge. The stimulus gets there by filling all 32 slots and reading partway into the oldest word. It then issues a push together with a request that carries the offset past bit 31. A long seeded random mix of pushes and requests follows. This mix takes both pointers around the store several times and hits many offset and length pairs near the word boundary, including requests that ask for just one bit more than the level.

// File: rtl/bitx_pkg.sv
package bitx_pkg;
    localparam int WORD_W = 32;
    localparam int DEPTH  = 32;
    localparam int LEN_W  = 4;

    typedef enum logic [1:0] {
        REQ_IDLE   = 2'd0,
        REQ_TAKE   = 2'd1,
        REQ_REJECT = 2'd2
    } req_res_e;

    function automatic int out_width(input int len_w);
        return (1 << len_w) - 1;
    endfunction
endpackage

// File: rtl/bitx_word_store.sv
module bitx_word_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata_cur,
    output logic [WORD_W-1:0] rdata_next
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  ridx_next;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign ridx_next  = ridx + IDX_W'(1);
    assign rdata_cur  = mem[ridx];
    assign rdata_next = mem[ridx_next];
endmodule

// File: rtl/bitx_aligner.sv
module bitx_aligner #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 4,
    localparam int OFF_W = $clog2(WORD_W),
    localparam int OUT_W = (1 << LEN_W) - 1,
    localparam int PAIR_W = 2 * WORD_W
) (
    input  logic [WORD_W-1:0] word_cur,
    input  logic [WORD_W-1:0] word_next,
    input  logic [OFF_W-1:0]  offset,
    input  logic [LEN_W-1:0]  len,
    output logic [OUT_W-1:0]  piece
);
    logic [PAIR_W-1:0] stage [OFF_W+1];
    logic [OUT_W-1:0]  keep_mask;

    assign stage[0] = {word_next, word_cur};

    for (genvar s = 0; s < OFF_W; s++) begin : g_shift
        assign stage[s+1] = offset[s] ? (stage[s] >> (1 << s)) : stage[s];
    end

    always_comb begin
        keep_mask = '0;
        for (int i = 0; i < OUT_W; i++) begin
            keep_mask[i] = (i < int'(len));
        end
    end

    assign piece = stage[OFF_W][OUT_W-1:0] & keep_mask;
endmodule

// File: rtl/bitx_ctrl.sv
module bitx_ctrl
    import bitx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 32,
    parameter int LEN_W  = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int OFF_W = $clog2(WORD_W),
    localparam int PTR_W = IDX_W + OFF_W,
    localparam int CNT_W = $clog2(DEPTH * WORD_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             req,
    input  logic [LEN_W-1:0] req_len,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_word,
    output logic [OFF_W-1:0] rd_off,
    output req_res_e         req_res,
    output logic             push_drop,
    output logic             full,
    output logic [CNT_W-1:0] bit_cnt
);
    logic [IDX_W:0]   used;
    logic             req_ok;
    logic             crossing;
    logic [OFF_W:0]   off_sum;
    logic [PTR_W-1:0] rd_ptr_next;

    assign full      = (used == (IDX_W+1)'(DEPTH));
    assign wr_en     = push && !full;
    assign push_drop = push && full;
    assign req_ok    = req && (CNT_W'(req_len) <= bit_cnt);
    assign off_sum   = {1'b0, rd_off} + (OFF_W+1)'(req_len);
    assign crossing  = off_sum[OFF_W];
    assign rd_ptr_next = {rd_word, rd_off} + PTR_W'(req_len);

    always_comb begin
        if (!req)        req_res = REQ_IDLE;
        else if (req_ok) req_res = REQ_TAKE;
        else             req_res = REQ_REJECT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx  <= '0;
            rd_word <= '0;
            rd_off  <= '0;
            used    <= '0;
            bit_cnt <= '0;
        end else begin
            if (wr_en) begin
                wr_idx <= wr_idx + IDX_W'(1);
            end
            if (req_ok) begin
                {rd_word, rd_off} <= rd_ptr_next;
            end
            used <= used + (IDX_W+1)'(wr_en) - (IDX_W+1)'(req_ok && crossing);
            bit_cnt <= bit_cnt
                       + (wr_en  ? CNT_W'(WORD_W)  : '0)
                       - (req_ok ? CNT_W'(req_len) : '0);
        end
    end

    // R9: the bit count agrees with slot occupancy and read offset
    p_count_consistent_r9: assert property (@(posedge clk) disable iff (rst)
        int'(bit_cnt) == int'(used) * WORD_W - int'(rd_off));

    // R9: the level never exceeds the store capacity
    p_level_bound_r9: assert property (@(posedge clk) disable iff (rst)
        int'(bit_cnt) <= DEPTH * WORD_W);

    // R7: a rejected request leaves the read position unchanged
    p_reject_holds_ptr_r7: assert property (@(posedge clk) disable iff (rst)
        (req_res == REQ_REJECT) |=> $stable({rd_word, rd_off}));
endmodule

// File: rtl/bitx_buffer.sv
module bitx_buffer
    import bitx_pkg::*;
#(
    parameter int WORD_W = bitx_pkg::WORD_W,
    parameter int DEPTH  = bitx_pkg::DEPTH,
    parameter int LEN_W  = bitx_pkg::LEN_W,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int OFF_W = $clog2(WORD_W),
    localparam int OUT_W = (1 << LEN_W) - 1,
    localparam int CNT_W = $clog2(DEPTH * WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              req,
    input  logic [LEN_W-1:0]  req_len,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data,
    output logic              full,
    output logic [CNT_W-1:0]  bit_level,
    output logic              overflow,
    output logic              underflow
);
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_word;
    logic [OFF_W-1:0]  rd_off;
    req_res_e          req_res;
    logic              push_drop;
    logic [WORD_W-1:0] word_cur;
    logic [WORD_W-1:0] word_next;
    logic [OUT_W-1:0]  piece;

    bitx_ctrl #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .req       (req),
        .req_len   (req_len),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .rd_word   (rd_word),
        .rd_off    (rd_off),
        .req_res   (req_res),
        .push_drop (push_drop),
        .full      (full),
        .bit_cnt   (bit_level)
    );

    bitx_word_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .we         (wr_en),
        .widx       (wr_idx),
        .wdata      (push_data),
        .ridx       (rd_word),
        .rdata_cur  (word_cur),
        .rdata_next (word_next)
    );

    bitx_aligner #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_align (
        .word_cur  (word_cur),
        .word_next (word_next),
        .offset    (rd_off),
        .len       (req_len),
        .piece     (piece)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            out_valid <= (req_res == REQ_TAKE);
            out_data  <= (req_res == REQ_TAKE) ? piece : '0;
            overflow  <= push_drop;
            underflow <= (req_res == REQ_REJECT);
        end
    end

    // R7: valid and underflow never coincide
    p_valid_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && underflow));

    // R3: a lone push into a full store does not raise the level
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (full && push && !req) |=> (bit_level == $past(bit_level)));

    // R3: overflow only follows a push while full
    p_overflow_cause_r3: assert property (@(posedge clk) disable iff (rst)
        overflow |-> $past(full && push));

    // R6: a zero-length request yields valid with zero data
    p_zero_len_r6: assert property (@(posedge clk) disable iff (rst)
        (req && req_len == '0) |=> (out_valid && out_data == '0));

    // R4: bits above the requested length are zero
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        req |=> ((out_data >> $past(req_len)) == '0));
endmodule

// File: tb/bitx_buffer_tb.sv
module bitx_buffer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push = 1'b0;
    logic [31:0] push_data = '0;
    logic        req = 1'b0;
    logic [3:0]  req_len = '0;
    logic        out_valid;
    logic [14:0] out_data;
    logic        full;
    logic [10:0] bit_level;
    logic        overflow;
    logic        underflow;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit m_q[$];
    int m_used = 0;
    int m_off  = 0;

    always #10 clk = ~clk;

    bitx_buffer u_dut (
        .clk(clk), .rst(rst), .push(push), .push_data(push_data),
        .req(req), .req_len(req_len), .out_valid(out_valid),
        .out_data(out_data), .full(full), .bit_level(bit_level),
        .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(string tag, string name, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, name, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic step(bit p, logic [31:0] d, bit r, int len, string tag);
        bit        e_valid = 0;
        bit        e_ovf   = 0;
        bit        e_unf   = 0;
        bit [14:0] e_data  = '0;
        bit        was_full;
        push = p; push_data = d; req = r; req_len = 4'(len);
        was_full = (m_used == 32);
        if (r) begin
            if (len <= m_q.size()) begin
                e_valid = 1;
                for (int i = 0; i < len; i++) e_data[i] = m_q.pop_front();
                if (m_off + len >= 32) begin
                    m_used--;
                    m_off = m_off + len - 32;
                end else begin
                    m_off = m_off + len;
                end
            end else begin
                e_unf = 1;
            end
        end
        if (p) begin
            if (!was_full) begin
                for (int i = 0; i < 32; i++) m_q.push_back(d[i]);
                m_used++;
            end else begin
                e_ovf = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        push = 0; req = 0;
        chk({tag, "/R4"}, "out_valid", out_valid, e_valid);
        chk({tag, "/R5"}, "out_data", out_data, e_data);
        chk({tag, "/R3"}, "overflow", overflow, e_ovf);
        chk({tag, "/R7"}, "underflow", underflow, e_unf);
        chk({tag, "/R9"}, "full", full, m_used == 32);
        chk({tag, "/R2"}, "bit_level", bit_level, m_q.size());
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int len;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "bit_level", bit_level, 0);
        chk("R1", "full", full, 0);
        chk("R1", "out_valid", out_valid, 0);
        chk("R1", "out_data", out_data, 0);
        chk("R1", "overflow", overflow, 0);
        chk("R1", "underflow", underflow, 0);

        // R7: request on empty store
        step(0, '0, 1, 3, "R7");
        // R2: pushes of distinct patterns
        step(1, 32'hA5C3_0F81, 0, 0, "R2");
        step(1, 32'h1234_5678, 0, 0, "R2");
        step(1, 32'hFFFF_0001, 0, 0, "R2");
        // R6: zero length
        step(0, '0, 1, 0, "R6");
        // R4 and R5: pieces crossing the first boundary
        step(0, '0, 1, 5, "R4");
        step(0, '0, 1, 15, "R4");
        step(0, '0, 1, 15, "R5");
        step(0, '0, 1, 15, "R5");
        step(0, '0, 1, 1, "R5");
        // R8: push and request together
        step(1, 32'hDEAD_BEEF, 1, 13, "R8");
        step(1, 32'h0F0F_F0F0, 1, 9, "R8");
        // R7: one bit more than held after draining to a small level
        while (m_q.size() > 15) step(0, '0, 1, 15, "R7");
        len = m_q.size();
        if (len < 15) step(0, '0, 1, len + 1, "R7");
        step(0, '0, 1, len, "R4");

        // R9 and R3: fill to full then overflow
        while (m_used < 32) step(1, $urandom, 0, 0, "R9");
        step(1, 32'h5555_AAAA, 0, 0, "R3");
        step(0, '0, 1, 10, "R9");
        step(0, '0, 1, 12, "R9");
        // push dropped although this request frees a slot
        step(1, 32'h7777_1111, 1, 15, "R3");
        step(1, 32'h3333_CCCC, 0, 0, "R9");
        step(1, 32'h4444_EEEE, 0, 0, "R3");

        // R10: full drain then random traffic wrapping the store
        while (m_q.size() > 0) begin
            len = (m_q.size() > 15) ? 15 : m_q.size();
            step(0, '0, 1, len, "R10");
        end
        for (int k = 0; k < 6000; k++) begin
            bit p = ($urandom % 100) < 45;
            bit r = ($urandom % 100) < 70;
            step(p, $urandom, r, $urandom % 16, "R10");
        end
        finish_run();
    end
endmodule